// File: doc/BRIEF.md
# Buffered SPI Master with Queued Frames

This block is an SPI master that decouples software from the serial line with a small transmit queue and a small receive queue. Software queues outgoing frames by writing them through a register-style write port. A shift engine takes frames from the head of the transmit queue on its own. It shifts each one out MSB first in SPI mode 0 and clocks the returned bits into a frame that goes into the receive queue. Software removes received frames through a read strobe, and the oldest frame is always visible on the read data port.

The block keeps four status conditions: a sticky overrun bit, an idle bit, a receive-pending bit and a transmit-room bit. Each status bit has its own enable, and the enabled bits are ORed onto one interrupt line. Software then reads the status bits to find the cause. Because the transmit queue holds several frames, an interrupt handler can top it up with a few frames at a time. Consecutive queued frames go out back to back with chip select held low.

Top module: `spi_buf_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, irq is 0 and status is 4'b1010: bit 3 (transmit room) is 1, bit 2 (receive pending) is 0, bit 1 (idle) is 1 and bit 0 (overrun) is 0.
- R2: Each accepted frame written with wr_sel=0 is sent exactly once, in write order, MSB first. mosi is stable at each rising sclk edge, and sclk idles low (mode 0).
- R3: The sclk period is 2*(DIV+1) system clocks. DIV is wr_data[7:4] of a wr_sel=1 write, and the period holds between the frames of a back-to-back burst as well.
- R4: miso is sampled on each rising sclk edge, MSB first. Each completed frame enters the receive queue, rd_data shows the oldest entry, and a rd_en pulse removes it.
- R5: The transmit queue holds four frames. A data write while it holds four frames is discarded and the queued frames are unchanged, even if the shifter takes a frame in that same cycle.
- R6: A discarded data write sets status bit 0 on the next cycle. The bit stays set until a wr_sel=2 write with wr_data[0]=1 clears it.
- R7: When a frame completes while the receive queue holds four frames and no read happens in that cycle, the new frame is dropped and the older entries are kept.
- R8: Status bit 2 is 1 while the receive queue is non-empty. Bit 3 is 1 while the transmit queue has a free entry. Bit 1 is 1 when the transmit queue is empty and no frame is shifting.
- R9: irq is the OR of (status AND enable), where the enable bits are wr_data[3:0] of a wr_sel=1 write, bit for bit matching the status bits.
- R10: cs_n goes low when a frame starts. It stays low across frames while queued data remains, and it returns high only when the shifter goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 data, 1 control, 2 status clear |
| wr_data | input | 8 | Write value |
| rd_en | input | 1 | Pops the oldest received frame |
| rd_data | output | 8 | Oldest received frame |
| status | output | 4 | {tx room, rx pending, idle, overrun} |
| irq | output | 1 | Combined maskable interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |

## Verification
Two collisions matter here. A data write can land on the very edge where the shifter takes a frame from a full transmit queue. A receive-queue read can fall on the edge where a frame completes into a full receive queue. Random stimulus with small clock divisors and a dense mix of writes and reads makes both collisions frequent. The bench loops miso back as the inverse of mosi, so every received value follows from the frame sent. Its model decides acceptance from the fill state before each edge, and it judges every frame on the serial line and every value read against that model.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
    localparam int ST_OVR  = 0;
    localparam int ST_IDLE = 1;
    localparam int ST_RXF  = 2;
    localparam int ST_TXF  = 3;
    localparam int ST_W    = 4;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_NONE = 2'd3
    } wr_sel_e;
endpackage

// File: rtl/spi_buf_fifo.sv
module spi_buf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)) else $error("fifo count above depth"); // R5
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q.cnt == CW'(DEPTH)) |=> $stable(st_q.cnt) && $stable(st_q.mem)) else $error("full fifo changed"); // R5
endmodule

// File: rtl/spi_buf_shifter.sv
module spi_buf_shifter #(
    parameter int W     = 8,
    parameter int DIV_W = 4,
    localparam int BW   = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             tx_valid,
    input  logic [W-1:0]     tx_frame,
    output logic             tx_pop,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n,
    output logic             busy,
    output logic             rx_done,
    output logic [W-1:0]     rx_frame
);
    typedef struct packed {
        logic             busy;
        logic             sclk;
        logic             cs_n;
        logic [DIV_W-1:0] cnt;
        logic [BW-1:0]    bits;
        logic [W-1:0]     tx_sh;
        logic [W-1:0]     rx_sh;
    } shf_t;

    shf_t sh_d, sh_q;
    logic half_end, last_bit, done, load;

    always_comb begin
        sh_d     = sh_q;
        half_end = (sh_q.cnt == div);
        last_bit = (sh_q.bits == BW'(W - 1));
        done     = sh_q.busy && half_end && sh_q.sclk && last_bit;
        load     = tx_valid && (!sh_q.busy || done);
        if (sh_q.busy) begin
            sh_d.cnt = half_end ? '0 : sh_q.cnt + 1'b1;
            if (half_end) begin
                if (!sh_q.sclk) begin
                    sh_d.sclk  = 1'b1;
                    sh_d.rx_sh = {sh_q.rx_sh[W-2:0], miso};
                end else begin
                    sh_d.sclk = 1'b0;
                    if (last_bit) begin
                        sh_d.busy = 1'b0;
                        sh_d.cs_n = 1'b1;
                    end else begin
                        sh_d.tx_sh = sh_q.tx_sh << 1;
                        sh_d.bits  = sh_q.bits + 1'b1;
                    end
                end
            end
        end
        if (load) begin
            sh_d.busy  = 1'b1;
            sh_d.cs_n  = 1'b0;
            sh_d.sclk  = 1'b0;
            sh_d.cnt   = '0;
            sh_d.bits  = '0;
            sh_d.tx_sh = tx_frame;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sh_q.cs_n <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign tx_pop   = load;
    assign rx_done  = done;
    assign rx_frame = sh_q.rx_sh;
    assign mosi     = sh_q.tx_sh[W-1];
    assign sclk     = sh_q.sclk;
    assign cs_n     = sh_q.cs_n;
    assign busy     = sh_q.busy;

    AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_q.busy |-> (sh_q.cs_n && !sh_q.sclk)) else $error("line active while idle"); // R10
    AST_SCLK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.busy && !half_end && !load) |=> $stable(sh_q.sclk)) else $error("sclk moved mid half period"); // R3
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.busy && !sh_q.sclk && half_end) |=> $stable(sh_q.tx_sh)) else $error("mosi changed at rising edge"); // R2
endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
    import spi_buf_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int DEPTH   = 4,
    parameter int DIV_W   = 4,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic               rd_en,
    output logic [FRAME_W-1:0] rd_data,
    output logic [ST_W-1:0]    status,
    output logic               irq,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    input  logic               miso
);
    typedef struct packed {
        logic             ovr;
        logic [ST_W-1:0]  ien;
        logic [DIV_W-1:0] div;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CW-1:0]      tx_count, rx_count;
    logic [FRAME_W-1:0] tx_head, rx_frame;
    logic               tx_push, tx_drop, tx_pop, clr_hit;
    logic               rx_done, busy, tx_full, tx_empty, rx_full, rx_empty;

    assign tx_full  = (tx_count == CW'(DEPTH));
    assign tx_empty = (tx_count == '0);
    assign rx_full  = (rx_count == CW'(DEPTH));
    assign rx_empty = (rx_count == '0);

    always_comb begin
        ctl_d   = ctl_q;
        tx_push = wr_en && (wr_sel_e'(wr_sel) == SEL_DATA);
        tx_drop = tx_push && tx_full;
        clr_hit = wr_en && (wr_sel_e'(wr_sel) == SEL_CLR) && wr_data[ST_OVR];
        if (wr_en && (wr_sel_e'(wr_sel) == SEL_CTRL)) begin
            ctl_d.ien = wr_data[ST_W-1:0];
            ctl_d.div = wr_data[ST_W +: DIV_W];
        end
        if (clr_hit) ctl_d.ovr = 1'b0;
        if (tx_drop) ctl_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    spi_buf_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(wr_data),
        .pop(tx_pop), .head(tx_head), .count(tx_count)
    );

    spi_buf_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_done), .push_data(rx_frame),
        .pop(rd_en), .head(rd_data), .count(rx_count)
    );

    spi_buf_shifter #(.W(FRAME_W), .DIV_W(DIV_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .div(ctl_q.div),
        .tx_valid(!tx_empty), .tx_frame(tx_head), .tx_pop(tx_pop),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .busy(busy), .rx_done(rx_done), .rx_frame(rx_frame)
    );

    always_comb begin
        status          = '0;
        status[ST_OVR]  = ctl_q.ovr;
        status[ST_IDLE] = tx_empty && !busy;
        status[ST_RXF]  = !rx_empty;
        status[ST_TXF]  = !tx_full;
    end

    assign irq = |(status & ctl_q.ien);

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drop |=> status[ST_OVR]) else $error("drop did not flag overrun"); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ovr && !clr_hit) |=> ctl_q.ovr) else $error("overrun lost without clear"); // R6
    AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_full && !rd_en) |=> $stable(rx_count) && $stable(rd_data)) else $error("full rx queue disturbed"); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_IDLE] |-> cs_n) else $error("idle flagged while selected"); // R8
endmodule

// File: tb/spi_buf_master_test.sv
`timescale 1ns/1ps
module spi_buf_master_test;
    localparam int DEPTH = 4;
    localparam int S_OVR = 0, S_IDLE = 1, S_RXF = 2, S_TXF = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] status;
    logic       irq, sclk, mosi, cs_n, miso;

    assign miso = ~mosi;

    spi_buf_master uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .status(status), .irq(irq), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .miso(miso)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cur_div = 0;
    int frames_seen = 0;
    int cs_rises = 0;
    int accepted = 0;
    bit rd_pop_now = 1'b0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // serial-line monitor, samples 1 ns after each rising clock edge
    logic [7:0] mon_sh = 8'h00;
    int  mon_bits = 0;
    int  cyc = 0;
    bit  have_rise = 1'b0;
    logic prev_sclk = 1'b0;
    logic prev_cs = 1'b1;
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            cyc++;
            if (cs_n) have_rise = 1'b0;
            if (sclk && !prev_sclk) begin
                if (have_rise)
                    chk(cyc == 2 * (cur_div + 1), "R3 sclk period", cyc, 2 * (cur_div + 1));
                have_rise = 1'b1;
                cyc = 0;
                mon_sh = {mon_sh[6:0], mosi};
                mon_bits++;
            end
            if (!sclk && prev_sclk && mon_bits == 8) begin
                mon_bits = 0;
                frames_seen++;
                if (txq.size() == 0) begin
                    chk(1'b0, "R2 unexpected frame", mon_sh, 0);
                end else begin
                    chk(mon_sh == txq[0], "R2 frame order", mon_sh, txq[0]);
                    void'(txq.pop_front());
                end
                if (rxq.size() + int'(rd_pop_now) < DEPTH) rxq.push_back(~mon_sh);
            end
            if (cs_n && !prev_cs) cs_rises++;
            prev_sclk = sclk;
            prev_cs = cs_n;
        end
        rd_pop_now = 1'b0;
    end

    // tasks enter at a falling edge and return at a later falling edge
    task automatic drive_wr(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic put(input logic [7:0] d);
        bit room;
        room = status[S_TXF];
        if (room) begin
            txq.push_back(d);
            accepted++;
        end
        drive_wr(2'd0, d);
        if (!room) chk(status[S_OVR] == 1'b1, "R6 drop sets overrun", status[S_OVR], 1);
    endtask

    task automatic take();
        chk(status[S_RXF] == (rxq.size() != 0), "R8 rx pending flag", status[S_RXF], rxq.size() != 0);
        if (rxq.size() != 0) begin
            chk(rd_data == rxq[0], "R4 read value", rd_data, rxq[0]);
            void'(rxq.pop_front());
            rd_pop_now = 1'b1;
        end
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_ctl(input int div, input logic [3:0] en);
        drive_wr(2'd1, {div[3:0], en});
        cur_div = div;
    endtask

    task automatic clear_ovr();
        drive_wr(2'd2, 8'h01);
        chk(status[S_OVR] == 1'b0, "R6 clear", status[S_OVR], 0);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && !status[S_IDLE]; i++) @(negedge clk);
        @(negedge clk);
        chk(status[S_IDLE] == 1'b1 && txq.size() == 0, "R8 idle after drain", status, 2);
    endtask

    initial begin
        #1_500_000;
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 line idle", {cs_n, sclk}, 2);
        chk(status == 4'b1010, "R1 status", status, 4'b1010);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // burst of six: five accepted, sixth dropped (R5, R6, R7, R10)
        set_ctl(3, 4'b0000);
        cs_rises = 0;
        frames_seen = 0;
        accepted = 0;
        put(8'hA5); put(8'h3C); put(8'hF0); put(8'h0F); put(8'h81); put(8'h7E);
        chk(accepted == 5, "R5 accepted count", accepted, 5);
        chk(status[S_TXF] == 1'b0, "R5 queue full", status[S_TXF], 0);
        @(negedge clk);
        chk(status[S_OVR] == 1'b1, "R6 sticky", status[S_OVR], 1);
        clear_ovr();
        wait_idle();
        chk(frames_seen == 5, "R2 frame count", frames_seen, 5);
        chk(cs_rises == 1, "R10 single select window", cs_rises, 1);
        chk(rxq.size() == 4, "R7 model kept four", rxq.size(), 4);
        chk(rd_data == 8'h5A, "R4 oldest first", rd_data, 8'h5A);
        repeat (4) take();
        chk(status[S_RXF] == 1'b0, "R7 fifth frame dropped", status[S_RXF], 0);

        // interrupt masking (R9)
        set_ctl(1, 4'b0000);
        chk(irq == 1'b0, "R9 all masked", irq, 0);
        set_ctl(1, 4'b0010);
        chk(irq == 1'b1, "R9 idle enabled", irq, 1);
        set_ctl(1, 4'b0100);
        chk(irq == 1'b0, "R9 rx enabled empty", irq, 0);
        set_ctl(1, 4'b1000);
        chk(irq == 1'b1, "R9 tx room enabled", irq, 1);
        set_ctl(1, 4'b0100);
        put(8'hC3);
        wait_idle();
        chk(irq == 1'b1, "R9 rx pending raises irq", irq, 1);
        take();
        chk(irq == 1'b0, "R9 rx drained", irq, 0);

        // random traffic at several divisors (R2 R3 R4 R5 R6 R7 R8)
        for (int ph = 0; ph < 3; ph++) begin
            set_ctl(ph, 4'b0000);
            for (int k = 0; k < 400; k++) begin
                int r;
                r = $urandom_range(0, 9);
                if (r < 4)       put(8'($urandom));
                else if (r < 7)  take();
                else if (r == 7) clear_ovr();
                else             @(negedge clk);
            end
            wait_idle();
            for (int k = 0; k < 8 && rxq.size() != 0; k++) take();
            chk(status[S_RXF] == 1'b0, "R8 rx drained", status[S_RXF], 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule